// File: doc/BRIEF.md
# Port change interrupt generator

This block watches an 8-bit parallel port and raises an active-low interrupt when the live pin value no longer matches a snapshot held in a compare register. A host then learns that an input changed without having to poll the serial bus. The serial controller beside it supplies two one-cycle reload strobes. One arrives on the falling serial-clock edge of a write data-acknowledge cycle, the other on the rising serial-clock edge of a read acknowledge cycle. It also supplies two window flags that hold the interrupt inactive: one covers every acknowledge cycle of a write, the other covers only the address acknowledge cycle of a read.

A mismatch must persist before it is reported. A glitch filter FSM with states QUIET, COUNT and FIRE counts consecutive clocks of mismatch. QUIET moves to COUNT on the first mismatch clock. COUNT moves to FIRE when the count reaches `FILT_CYCLES`, and returns to QUIET when the mismatch vanishes. FIRE returns to QUIET when the port matches again. Any reload sends the FSM to QUIET from every state. At 50 MHz the default of 21 clocks rejects mismatches shorter than about 420 ns.

Top module: `port_chg_irq`

## Requirements
- R1: After reset `irq_n` is 1 and the compare register holds all ones, so a port held at all ones never raises the interrupt.
- R2: A difference in any single bit between `port_in` and the compare register drives `irq_n` to 0 after exactly `FILT_CYCLES` consecutive clock edges of mismatch, and not after `FILT_CYCLES`-1.
- R3: A mismatch that lasts fewer than `FILT_CYCLES` clocks never lowers `irq_n`, and the count starts over from zero on the next mismatch.
- R4: When the port returns to the captured value, `irq_n` returns to 1 at the next clock edge.
- R5: A one-cycle `cap_wr` pulse loads `port_in` into the compare register and sets `irq_n` to 1 at that same edge. Later comparisons use the new value.
- R6: A one-cycle `cap_rd` pulse behaves the same way as `cap_wr`.
- R7: While `mask_wr_ack` is 1, `irq_n` is 1 in the same cycle. Over a multi-byte write in which the port changes with each byte and a reload follows each byte, the interrupt never asserts.
- R8: While `mask_rd_addr_ack` is 1, `irq_n` is 1. Once the flag drops, a pending interrupt is visible again in the same cycle.
- R9: When a port change and a reload strobe occur on the same edge, the compare register takes the new port value and no interrupt follows.
- R10: While the mismatch stays present, the asserted interrupt remains low for any length of time, with the count saturated.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| port_in | input | WIDTH | Live port pin value |
| cap_wr | input | 1 | Reload strobe, write data acknowledge |
| cap_rd | input | 1 | Reload strobe, read acknowledge |
| mask_wr_ack | input | 1 | Write acknowledge window; forces interrupt inactive |
| mask_rd_addr_ack | input | 1 | Read address acknowledge window; forces interrupt inactive |
| irq_n | output | 1 | Active-low interrupt |

## Verification
A reload of the compare register and a change on the port can land on the same clock edge. In that case the reload must win both in the register and in the filter FSM. The bench changes `port_in` and raises `cap_rd` at the same falling clock edge. It then waits well past the filter length and requires `irq_n` to stay 1. It also requires that a later departure from that new value is reported, which shows that the captured value was the new one.

// File: rtl/port_chg_irq_pkg.sv
package port_chg_irq_pkg;
    typedef enum logic [1:0] {
        ST_QUIET = 2'd0,
        ST_COUNT = 2'd1,
        ST_FIRE  = 2'd2
    } filt_state_t;
endpackage

// File: rtl/pci_cmp_reg.sv
module pci_cmp_reg #(
    parameter int WIDTH = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [WIDTH-1:0] port_in,
    output logic [WIDTH-1:0] cmp_q,
    output logic             differs
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cmp_q <= '1;
        else if (load) cmp_q <= port_in;
    end

    // any bit apart means a pending change
    always_comb differs = |(port_in ^ cmp_q);
endmodule

// File: rtl/pci_glitch_fsm.sv
module pci_glitch_fsm
    import port_chg_irq_pkg::*;
#(
    parameter int FILT_CYCLES = 21
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        differs,
    input  logic        reload,
    output filt_state_t st,
    output logic        fire
);
    localparam int CW = $clog2(FILT_CYCLES + 1);
    localparam logic [CW-1:0] LIM    = CW'(FILT_CYCLES);
    localparam logic [CW-1:0] LIM_M1 = CW'(FILT_CYCLES - 1);

    filt_state_t      st_nx;
    logic [CW-1:0]    cnt, cnt_nx;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st  <= ST_QUIET;
            cnt <= '0;
        end else begin
            st  <= st_nx;
            cnt <= cnt_nx;
        end
    end

    always_comb begin
        st_nx  = st;
        cnt_nx = cnt;
        if (reload) begin
            st_nx  = ST_QUIET;
            cnt_nx = '0;
        end else begin
            unique case (st)
                ST_QUIET: if (differs) begin
                    st_nx  = ST_COUNT;
                    cnt_nx = CW'(1);
                end
                ST_COUNT: if (!differs) begin
                    st_nx  = ST_QUIET;
                    cnt_nx = '0;
                end else if (cnt == LIM_M1) begin
                    st_nx  = ST_FIRE;
                    cnt_nx = LIM;
                end else begin
                    cnt_nx = cnt + CW'(1);
                end
                ST_FIRE: if (!differs) begin
                    st_nx  = ST_QUIET;
                    cnt_nx = '0;
                end
                default: begin
                    st_nx  = ST_QUIET;
                    cnt_nx = '0;
                end
            endcase
        end
    end

    always_comb fire = (st == ST_FIRE);
endmodule

// File: rtl/port_chg_irq.sv
module port_chg_irq
    import port_chg_irq_pkg::*;
#(
    parameter int WIDTH       = 8,
    parameter int FILT_CYCLES = 21
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] port_in,
    input  logic             cap_wr,
    input  logic             cap_rd,
    input  logic             mask_wr_ack,
    input  logic             mask_rd_addr_ack,
    output logic             irq_n
);
    logic [WIDTH-1:0] cmp_q;
    logic             differs;
    logic             reload;
    logic             fire;
    filt_state_t      st;

    always_comb reload = cap_wr | cap_rd;

    pci_cmp_reg #(.WIDTH(WIDTH)) u_cmp (
        .clk(clk), .rst_n(rst_n), .load(reload), .port_in(port_in),
        .cmp_q(cmp_q), .differs(differs)
    );

    pci_glitch_fsm #(.FILT_CYCLES(FILT_CYCLES)) u_filt (
        .clk(clk), .rst_n(rst_n), .differs(differs), .reload(reload),
        .st(st), .fire(fire)
    );

    always_comb irq_n = ~fire | mask_wr_ack | mask_rd_addr_ack;
endmodule

// File: rtl/port_chg_irq_chk.sv
module port_chg_irq_chk
    import port_chg_irq_pkg::*;
#(
    parameter int WIDTH       = 8,
    parameter int FILT_CYCLES = 21
) (
    input logic             clk,
    input logic             rst_n,
    input logic [WIDTH-1:0] port_in,
    input logic             cap_wr,
    input logic             cap_rd,
    input logic             mask_wr_ack,
    input logic             mask_rd_addr_ack,
    input logic             irq_n,
    input logic [WIDTH-1:0] cmp_q,
    input filt_state_t      st
);
    a_r5_reload_clears: assert property (@(posedge clk) disable iff (!rst_n)
        (cap_wr || cap_rd) |=> (irq_n && st == ST_QUIET));

    a_r9_reload_takes_port: assert property (@(posedge clk) disable iff (!rst_n)
        (cap_wr || cap_rd) |=> (cmp_q == $past(port_in)));

    a_r7_wr_mask: assert property (@(posedge clk) disable iff (!rst_n)
        mask_wr_ack |-> irq_n);

    a_r8_rd_mask: assert property (@(posedge clk) disable iff (!rst_n)
        mask_rd_addr_ack |-> irq_n);

    a_r4_match_release: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_FIRE && port_in == cmp_q) |=> (st == ST_QUIET));

    a_r2_fire_needs_diff: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_FIRE && $past(st) != ST_FIRE) |-> $past(port_in != cmp_q));

    a_r3_no_skip: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_FIRE && $past(st) != ST_FIRE) |-> ($past(st) == ST_COUNT));
endmodule

bind port_chg_irq port_chg_irq_chk #(.WIDTH(WIDTH), .FILT_CYCLES(FILT_CYCLES)) u_chk (
    .clk(clk), .rst_n(rst_n), .port_in(port_in), .cap_wr(cap_wr), .cap_rd(cap_rd),
    .mask_wr_ack(mask_wr_ack), .mask_rd_addr_ack(mask_rd_addr_ack), .irq_n(irq_n),
    .cmp_q(cmp_q), .st(st)
);

// File: tb/port_chg_irq_test.sv
`timescale 1ns/1ps
module port_chg_irq_test;
    localparam int T = 21;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [7:0] port_in = 8'hFF;
    logic       cap_wr = 1'b0, cap_rd = 1'b0;
    logic       mask_wr_ack = 1'b0, mask_rd_addr_ack = 1'b0;
    logic       irq_n;
    int         checks = 0, errors = 0;
    bit         finished = 1'b0;

    always #10 clk = ~clk;

    port_chg_irq #(.WIDTH(8), .FILT_CYCLES(T)) uut (
        .clk(clk), .rst_n(rst_n), .port_in(port_in), .cap_wr(cap_wr), .cap_rd(cap_rd),
        .mask_wr_ack(mask_wr_ack), .mask_rd_addr_ack(mask_rd_addr_ack), .irq_n(irq_n)
    );

    task automatic chk(input string tag, input logic exp);
        checks++;
        if (irq_n !== exp) begin
            errors++;
            $display("FAIL %s irq_n actual %b expected %b at %0t", tag, irq_n, exp, $time);
        end
    endtask

    task automatic wait_n(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic pulse(input bit rd);
        if (rd) cap_rd = 1'b1; else cap_wr = 1'b1;
        @(negedge clk);
        cap_rd = 1'b0;
        cap_wr = 1'b0;
    endtask

    task automatic t_reset;
        rst_n = 1'b0;
        port_in = 8'hFF;
        wait_n(3);
        chk("R1 in reset", 1'b1);
        rst_n = 1'b1;
        wait_n(T + 3);
        chk("R1 all-ones idle", 1'b1);
    endtask

    task automatic t_bits;
        for (int b = 0; b < 8; b++) begin
            port_in = 8'hFF ^ (8'h01 << b);
            wait_n(T - 1);
            chk("R2 one short", 1'b1);
            wait_n(1);
            chk("R2 asserted", 1'b0);
            port_in = 8'hFF;
            wait_n(1);
            chk("R4 released", 1'b1);
        end
    endtask

    task automatic t_glitch;
        port_in = 8'hFE;
        wait_n(T - 1);
        port_in = 8'hFF;
        wait_n(1);
        chk("R3 glitch suppressed", 1'b1);
        port_in = 8'hFE;
        wait_n(T - 1);
        chk("R3 count restarted", 1'b1);
        wait_n(1);
        chk("R3 full length", 1'b0);
        port_in = 8'hFF;
        wait_n(1);
    endtask

    task automatic t_reload(input bit rd, input logic [7:0] v);
        string tag;
        tag = rd ? "R6" : "R5";
        port_in = v;
        wait_n(T + 2);
        chk({tag, " pending"}, 1'b0);
        pulse(rd);
        chk({tag, " cleared at reload"}, 1'b1);
        wait_n(T + 2);
        chk({tag, " stays clear"}, 1'b1);
        port_in = 8'hFF;
        wait_n(T);
        chk({tag, " new compare value"}, 1'b0);
        pulse(rd);
        chk({tag, " back to ones"}, 1'b1);
    endtask

    task automatic t_mask_wr;
        port_in = 8'h00;
        wait_n(T);
        chk("R7 pending", 1'b0);
        mask_wr_ack = 1'b1;
        #1 chk("R7 masked", 1'b1);
        mask_wr_ack = 1'b0;
        #1 chk("R7 unmasked", 1'b0);
        wait_n(1);
        mask_wr_ack = 1'b1;
        pulse(1'b0);
        for (int k = 1; k <= 3; k++) begin
            port_in = 8'(k * 8'h11);
            wait_n(2);
            chk("R7 multi-byte masked", 1'b1);
            pulse(1'b0);
        end
        mask_wr_ack = 1'b0;
        wait_n(T + 2);
        chk("R7 after multi-byte write", 1'b1);
    endtask

    task automatic t_mask_rd;
        port_in = 8'h44;
        wait_n(T);
        chk("R8 pending", 1'b0);
        mask_rd_addr_ack = 1'b1;
        #1 chk("R8 masked", 1'b1);
        wait_n(3);
        chk("R8 still masked", 1'b1);
        mask_rd_addr_ack = 1'b0;
        #1 chk("R8 visible again", 1'b0);
        wait_n(1);
    endtask

    task automatic t_same_cycle;
        port_in = 8'h77;
        cap_rd = 1'b1;
        wait_n(1);
        cap_rd = 1'b0;
        wait_n(T + 3);
        chk("R9 no interrupt", 1'b1);
        port_in = 8'h76;
        wait_n(T);
        chk("R9 new value captured", 1'b0);
        port_in = 8'h77;
        wait_n(1);
        chk("R9 release", 1'b1);
    endtask

    task automatic t_sat;
        port_in = 8'h00;
        wait_n(T);
        chk("R10 asserted", 1'b0);
        wait_n(200);
        chk("R10 holds", 1'b0);
        port_in = 8'h77;
        wait_n(1);
        chk("R10 release", 1'b1);
    endtask

    initial begin
        #(20 * 200000);
        if (!finished) begin
            checks++;
            errors++;
            $display("FAIL watchdog expired");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        @(negedge clk);
        t_reset();
        t_bits();
        t_glitch();
        t_reload(1'b0, 8'h5A);
        t_reload(1'b1, 8'h3C);
        t_mask_wr();
        t_mask_rd();
        t_same_cycle();
        t_sat();
        finished = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule